// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a small register window. Words written to the transmit data address go into a transmit FIFO. When the controller is enabled, set to master, and its transmit hold bit is clear, it shifts the queued words out on MOSI one after another. It captures one word from MISO for every word it sends and places it in a receive FIFO. Software empties that FIFO through the receive data address. Clock polarity, clock phase, bit order and an internal loopback path are control bits. The word width and the SCLK half-period are fixed by parameters.

The chip-select lines are active low and copy a software-written select register. A typical sequence is: set the hold bit, write the select register, load a batch of words, then clear the hold bit. The whole batch goes out under one chip select. A single-cycle event pulse marks the end of the last queued word. An interrupt block outside this controller can use that pulse. The register port is a plain single-cycle bus with no back-pressure. Writes take effect at the clock edge, and read data is combinational from the address. A write to a full transmit FIFO is dropped. A received word that arrives while the receive FIFO is full is dropped. Software avoids both by never queuing more words than the FIFO depth before draining.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset the control register reads 0x100 (hold bit 8 set, all else clear), status reads 0x05, the select register reads 0xFFFFFFFF, all chip selects are high and SCLK is low.
- R2: Status bit 3 (TX full) sets once DEPTH words are queued; further writes to the transmit address 0x68 are dropped.
- R3: While control bit 8 (hold) is set, SCLK does not toggle and queued words stay in the transmit FIFO; clearing it starts shifting.
- R4: Every word shifted out pushes exactly one received word, in order, into the receive FIFO read at address 0x6C.
- R5: Control bits 3 (CPOL) and 4 (CPHA) select the SPI mode: SCLK idles at CPOL; with CPHA=0 data is sampled on the first edge of each bit, with CPHA=1 on the second; MSB is sent and received first by default.
- R6: Control bit 9 set sends and receives the least significant bit first.
- R7: Control bit 0 (loopback) routes MOSI to the receiver and ignores the MISO pin.
- R8: Address 0x70 drives the NCS active-low chip selects directly from its low bits; bits at or above NCS read as ones.
- R9: Writing 1 to control bit 5 empties the transmit FIFO and writing 1 to bit 6 empties the receive FIFO; both bits read back as 0.
- R10: Reading the receive address while the receive FIFO is empty returns zero.
- R11: evt_tx_empty pulses for one cycle, once, when the last queued word finishes shifting.
- R12: Status at 0x64 reports bit 0 RX empty, bit 1 RX full, bit 2 TX empty, bit 3 TX full, bit 4 mode fault (always 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at 0x6C) |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NCS | Active-low chip selects |
| evt_tx_empty | output | 1 | Pulse: last queued word finished |

## Verification
The checker enforces several properties on every cycle. The hold bit always prevents a new word from starting. SCLK rests at CPOL whenever the shifter is idle. The chip selects follow each select write one cycle later. The end event only appears when the transmit FIFO is empty. An empty receive read always returns zero. Bit ordering in each SPI mode, the received data under external and loopback input, FIFO depth and drop behaviour, FIFO resets and the count of end events can only be shown by the bench. It does this with a behavioural slave that samples MOSI and drives MISO on the edges the mode prescribes.

// File: rtl/spih_pkg.sv
package spih_pkg;
  localparam logic [6:0] A_CTRL = 7'h60;
  localparam logic [6:0] A_STAT = 7'h64;
  localparam logic [6:0] A_TXD  = 7'h68;
  localparam logic [6:0] A_RXD  = 7'h6C;
  localparam logic [6:0] A_SSEL = 7'h70;

  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_MST   = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXRST = 5;
  localparam int CB_RXRST = 6;
  localparam int CB_MAN   = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSB   = 9;

  typedef struct packed {
    logic loop;
    logic cpol;
    logic cpha;
    logic lsb;
  } spih_mode_t;
endpackage

// File: rtl/spih_fifo.sv
module spih_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spih_shifter.sv
module spih_shifter
  import spih_pkg::*;
#(
  parameter int W    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  spih_mode_t   mode,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int HW = $clog2(HALF) + 1;
  localparam int EW = $clog2(2 * W) + 1;

  logic [HW-1:0] hcnt;
  logic [EW-1:0] edg;
  logic [W-1:0]  tsh, rsh;
  logic          lead, last, sbit;

  function automatic logic first_bit(input logic [W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[W-1];
  endfunction

  function automatic logic [W-1:0] advance(input logic [W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign lead    = ~edg[0];
  assign last    = (edg == EW'(2 * W - 1));
  assign sbit    = mode.loop ? mosi : miso;
  assign rx_word = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      hcnt <= '0;
      edg  <= '0;
      tsh  <= '0;
      rsh  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= mode.cpol;
        if (start) begin
          busy <= 1'b1;
          hcnt <= '0;
          edg  <= '0;
          if (!mode.cpha) begin
            mosi <= first_bit(tx_word, mode.lsb);
            tsh  <= advance(tx_word, mode.lsb);
          end else begin
            tsh  <= tx_word;
          end
        end
      end else if (hcnt == HW'(HALF - 1)) begin
        hcnt <= '0;
        sclk <= ~sclk;
        edg  <= edg + EW'(1);
        if (lead ^ mode.cpha)
          rsh <= mode.lsb ? {sbit, rsh[W-1:1]} : {rsh[W-2:0], sbit};
        if ((lead && mode.cpha) || (!lead && !mode.cpha && !last)) begin
          mosi <= first_bit(tsh, mode.lsb);
          tsh  <= advance(tsh, mode.lsb);
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spih_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter int HALF  = 2,
  parameter int NCS   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [6:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] ss_n,
  output logic           evt_tx_empty
);
  localparam logic [31:0] SS_KEEP = (NCS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NCS) - 32'd1);

  logic c_loop, c_en, c_mst, c_cpol, c_cpha, c_man, c_hold, c_lsb;
  logic [31:0] ssr;
  logic wr_ctrl, wr_txd, wr_ssel, rd_rxd;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [W-1:0] tx_head, rx_head, rx_word;
  logic sh_busy, sh_done, sh_start;
  spih_mode_t mode;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_txd  = bus_wr && (bus_addr == A_TXD);
  assign wr_ssel = bus_wr && (bus_addr == A_SSEL);
  assign rd_rxd  = bus_rd && (bus_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_loop, c_en, c_mst, c_cpol, c_cpha, c_man, c_lsb} <= '0;
      c_hold <= 1'b1;
      ssr    <= 32'hFFFF_FFFF;
    end else begin
      if (wr_ctrl) begin
        c_loop <= bus_wdata[CB_LOOP];
        c_en   <= bus_wdata[CB_EN];
        c_mst  <= bus_wdata[CB_MST];
        c_cpol <= bus_wdata[CB_CPOL];
        c_cpha <= bus_wdata[CB_CPHA];
        c_man  <= bus_wdata[CB_MAN];
        c_hold <= bus_wdata[CB_HOLD];
        c_lsb  <= bus_wdata[CB_LSB];
      end
      if (wr_ssel) ssr <= bus_wdata | ~SS_KEEP;
    end
  end

  assign ss_n = ssr[NCS-1:0];
  assign mode = '{loop: c_loop, cpol: c_cpol, cpha: c_cpha, lsb: c_lsb};
  assign sh_start = c_en && c_mst && !c_hold && !tx_empty && !sh_busy;
  assign evt_tx_empty = sh_done && tx_empty;

  spih_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(wr_ctrl && bus_wdata[CB_TXRST]),
    .push(wr_txd), .wdata(bus_wdata[W-1:0]), .pop(sh_start),
    .rdata(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spih_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(wr_ctrl && bus_wdata[CB_RXRST]),
    .push(sh_done), .wdata(rx_word), .pop(rd_rxd),
    .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spih_shifter #(.W(W), .HALF(HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_word(tx_head), .mode(mode),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(sh_busy), .done(sh_done),
    .rx_word(rx_word)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[CB_LOOP] = c_loop;
        bus_rdata[CB_EN]   = c_en;
        bus_rdata[CB_MST]  = c_mst;
        bus_rdata[CB_CPOL] = c_cpol;
        bus_rdata[CB_CPHA] = c_cpha;
        bus_rdata[CB_MAN]  = c_man;
        bus_rdata[CB_HOLD] = c_hold;
        bus_rdata[CB_LSB]  = c_lsb;
      end
      A_STAT:  bus_rdata[4:0] = {1'b0, tx_full, tx_empty, rx_full, rx_empty};
      A_RXD:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_head);
      A_SSEL:  bus_rdata = ssr;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spih_checker.sv
module spih_checker
  import spih_pkg::*;
#(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [6:0]     bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic           sclk,
  input logic [NCS-1:0] ss_n,
  input logic           evt_tx_empty,
  input logic           c_hold,
  input logic           c_cpol,
  input logic           sh_busy,
  input logic           tx_empty,
  input logic           rx_empty
);
  AST_HOLD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hold && !sh_busy) |=> !sh_busy);  // R3

  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_busy && !$past(sh_busy) && (c_cpol == $past(c_cpol))) |-> (sclk == c_cpol));  // R5

  AST_SEL_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SSEL) |=> (ss_n == $past(bus_wdata[NCS-1:0])));  // R8

  AST_EVT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_empty |-> tx_empty);  // R11

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXD && rx_empty) |-> (bus_rdata == 32'd0));  // R10
endmodule

bind spi_host_ctl spih_checker #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .ss_n(ss_n),
  .evt_tx_empty(evt_tx_empty), .c_hold(c_hold), .c_cpol(c_cpol), .sh_busy(sh_busy),
  .tx_empty(tx_empty), .rx_empty(rx_empty)
);

// File: tb/tb_spi_host_ctl.sv
module tb_spi_host_ctl;
  localparam logic [6:0] A_CTRL = 7'h60, A_STAT = 7'h64, A_TXD = 7'h68, A_RXD = 7'h6C, A_SSEL = 7'h70;
  localparam logic [31:0] BASE = 32'h86;   // enable | master | manual select
  localparam logic [31:0] HOLD = 32'h100;

  // {cpol, cpha, lsb, loop, tx, reply}
  localparam logic [19:0] VEC [8] = '{
    {4'b0000, 8'hA5, 8'h3C},
    {4'b0100, 8'h96, 8'hC3},
    {4'b1000, 8'h81, 8'h7E},
    {4'b1100, 8'h5A, 8'h0F},
    {4'b0010, 8'hC8, 8'h13},
    {4'b1110, 8'h37, 8'hE1},
    {4'b0001, 8'h6B, 8'hFF},
    {4'b1011, 8'h2D, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sclk, mosi, miso;
  logic [3:0] ss_n;
  logic evt_tx_empty;

  int n_chk = 0, n_bad = 0, evt_cnt = 0, tgl = 0;
  logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
  logic [7:0] reply = '0, cap_sh = '0, cap_word = '0;
  logic [2:0] sidx = '0;

  always #4 clk = ~clk;

  spi_host_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .evt_tx_empty(evt_tx_empty)
  );

  // behavioural slave on select line 0
  assign miso = m_lsb ? reply[sidx] : reply[3'd7 - sidx];

  always @(sclk) begin
    tgl <= tgl + 1;
    if (!ss_n[0] && (sclk == (m_cpol ^ ~m_cpha))) begin
      cap_sh <= m_lsb ? {mosi, cap_sh[7:1]} : {cap_sh[6:0], mosi};
      if (sidx == 3'd7) cap_word <= m_lsb ? {mosi, cap_sh[7:1]} : {cap_sh[6:0], mosi};
      sidx <= sidx + 3'd1;
    end
  end

  always @(posedge clk) if (rst_n && evt_tx_empty) evt_cnt <= evt_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_evt(input int snap, input string req);
    int k = 0;
    while (evt_cnt == snap && k < 2000) begin
      @(posedge clk);
      k++;
    end
    chk(req, 32'(evt_cnt != snap), 32'd1);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, mb;
    logic lp;
    logic [7:0] tx;
    int snap, ts;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bread(A_CTRL, d); chk("R1 ctrl", d, 32'h100);
    bread(A_STAT, d); chk("R1 status", d, 32'h05);
    bread(A_SSEL, d); chk("R1 select", d, 32'hFFFF_FFFF);
    chk("R1 ss_n", 32'(ss_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 32'd0);

    // vector table: modes, bit order, loopback
    for (int i = 0; i < 8; i++) begin
      {m_cpol, m_cpha, m_lsb, lp} = VEC[i][19:16];
      tx = VEC[i][15:8];
      reply = VEC[i][7:0];
      mb = BASE | 32'(lp) | (32'(m_cpol) << 3) | (32'(m_cpha) << 4) | (32'(m_lsb) << 9);
      bwrite(A_SSEL, 32'hFFFF_FFFF);
      bwrite(A_CTRL, mb | HOLD);
      repeat (4) @(posedge clk);
      chk("R5 idle level", 32'(sclk), 32'(m_cpol));
      bwrite(A_SSEL, 32'hFFFF_FFFE);
      bwrite(A_TXD, 32'(tx));
      snap = evt_cnt;
      bwrite(A_CTRL, mb);
      wait_evt(snap, "R11 end event");
      bwrite(A_CTRL, mb | HOLD);
      chk(m_lsb ? "R6 mosi order" : "R5 mosi order", 32'(cap_word), 32'(tx));
      bread(A_RXD, d);
      chk(lp ? "R7 loopback rx" : (m_lsb ? "R6 rx order" : "R5 rx sample"), d, lp ? 32'(tx) : 32'(reply));
    end

    // burst in loopback: depth, hold, ordering, single event
    m_cpol = 0; m_cpha = 0; m_lsb = 0;
    bwrite(A_CTRL, BASE | HOLD | 32'h1);
    for (int k = 1; k <= 5; k++) bwrite(A_TXD, 32'h11 * k);
    bread(A_STAT, d); chk("R2 tx full", d, 32'h09);
    ts = tgl;
    repeat (50) @(posedge clk);
    chk("R3 no sclk under hold", 32'(tgl), 32'(ts));
    bread(A_STAT, d); chk("R3 queue kept", d, 32'h09);
    snap = evt_cnt;
    bwrite(A_CTRL, BASE | 32'h1);
    wait_evt(snap, "R3 start after release");
    repeat (100) @(posedge clk);
    chk("R11 single pulse", 32'(evt_cnt - snap), 32'd1);
    bread(A_STAT, d); chk("R12 rx full tx empty", d, 32'h06);
    for (int k = 1; k <= 4; k++) begin
      bread(A_RXD, d); chk("R4 word order", d, 32'h11 * k);
    end
    bread(A_RXD, d); chk("R10 empty read zero", d, 32'd0);
    bread(A_STAT, d); chk("R2 fifth word dropped", d, 32'h05);

    // FIFO resets
    bwrite(A_CTRL, BASE | HOLD | 32'h1);
    bwrite(A_TXD, 32'h55); bwrite(A_TXD, 32'h66);
    bwrite(A_CTRL, BASE | HOLD | 32'h1 | 32'h20);
    bread(A_STAT, d); chk("R9 tx flush", d, 32'h05);
    bread(A_CTRL, d); chk("R9 self clear", d, 32'h187);
    bwrite(A_TXD, 32'h77); bwrite(A_TXD, 32'h88);
    snap = evt_cnt;
    bwrite(A_CTRL, BASE | 32'h1);
    wait_evt(snap, "R9 transfer");
    bwrite(A_CTRL, BASE | HOLD | 32'h1);
    bread(A_STAT, d); chk("R12 rx data present", d, 32'h04);
    bwrite(A_CTRL, BASE | HOLD | 32'h1 | 32'h40);
    bread(A_STAT, d); chk("R9 rx flush", d, 32'h05);

    // select register
    bwrite(A_SSEL, 32'h0000_0005);
    chk("R8 ss_n pins", 32'(ss_n), 32'h5);
    bread(A_SSEL, d); chk("R8 upper bits ones", d, 32'hFFFF_FFF5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule